// File: doc/BRIEF.md
# Diode Emulation Mode Controller

This block is the digital decision logic of a single-phase buck controller. It decides whether the converter runs in continuous conduction or in diode emulation. In continuous conduction the low-side switch acts as a synchronous rectifier. In diode emulation the low-side switch blocks reverse inductor current. The block watches the high-side gate command and the output of a comparator that reports when the switch node is above ground. From these two signals it classifies every switching cycle. A cycle is counted as having reverse (negative) inductor current if the comparator fired while the high side was off, once a short blanking interval had passed. Otherwise the cycle is counted as having forward (positive) current.

A fixed run of consecutive cycles of one polarity moves the block between the two modes. A polarity change in the middle of a run restarts the count. Three static inputs set the operating profile: a mode bit and two strap pins. The profile decides whether diode emulation is permitted, which enlarged ripple window the modulator uses while emulating, and whether a periodic low-side "keep-alive" pulse is produced. That pulse stops the switching frequency from falling into the audible range.

Top module: `dem_ctrl`

## Requirements
- R1: After reset the block is in continuous conduction (`dem_active`=0), `win_sel` is 0 (nominal) and `lg_pulse` is 0.
- R2: With emulation permitted, the block enters diode emulation at the rising edge of `hs_cmd` that ends the third consecutive negative-current cycle. `dem_active` reads 1 from the next clock.
- R3: In diode emulation, the block returns to continuous conduction at the rising edge of `hs_cmd` that ends the third consecutive positive-current cycle.
- R4: A cycle whose polarity is opposite to the run in progress restarts that run. A count of two followed by one opposite cycle therefore needs three fresh cycles before any mode change.
- R5: `ph_pos` is ignored while `hs_cmd` is high and during the first `BLANK_CYC` sampled clocks of each low period (default 4 in the bench).
- R6: Once `ph_pos` is seen inside the valid window, the cycle is classified as negative even if `ph_pos` drops again before `hs_cmd` rises. The held result is cleared at each rising edge of `hs_cmd`.
- R7: With `gpu_mode2`=0: if `cfg_emu`=0, emulation is never entered and `win_sel` stays 0; if `cfg_emu`=1, emulation is permitted and uses window code 1 (130%).
- R8: With `gpu_mode2`=1 emulation is always permitted. The window code is 2 (150%) when `cfg_aud`=0 and 1 (130%) when `cfg_aud`=1.
- R9: `win_sel` uses code 0 = nominal, 1 = 130%, 2 = 150%, never 3. It reads 0 whenever `dem_active` is 0.
- R10: The keep-alive pulse runs only when `gpu_mode2`=1, `cfg_aud`=1, `cfg_emu`=0 and `dem_active`=1. `lg_pulse` is then high for `AF_WIDTH` clocks in every `AF_PERIOD` clocks. The first pulse starts `AF_PERIOD-AF_WIDTH` clocks after entry into emulation.
- R11: If the profile stops permitting emulation, `dem_active` drops at the next clock and both run counts clear. Re-entry then needs three new negative cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd | input | 1 | High-side gate command (1 = on) |
| ph_pos | input | 1 | Comparator: switch node above ground |
| gpu_mode2 | input | 1 | Operating-profile select (0 = profile one, 1 = profile two) |
| cfg_emu | input | 1 | Strap pin: emulation permit / keep-alive inhibit |
| cfg_aud | input | 1 | Strap pin: window choice and keep-alive request in profile two |
| dem_active | output | 1 | 1 while in diode emulation |
| win_sel | output | 2 | Ripple-window code: 0 nominal, 1 130%, 2 150% |
| lg_pulse | output | 1 | Keep-alive low-side gate pulse |

## Verification
The bound checker watches several relations on every clock. The window code is never 3 and is nominal outside emulation. A forbidding profile in profile one always forces conduction mode. The keep-alive pulse appears only while emulating under the right straps. Entry into emulation coincides with a rising gate edge. Run counters stay below the run length. The counting itself can only be shown by the bench's pulse sequences: the consecutive-run rule with interrupted runs, the exact blanking boundary, the held comparator result, and the keep-alive period, width and first-pulse delay.

// File: rtl/dem_pkg.sv
package dem_pkg;

   typedef enum logic [1:0] {
      WIN_NOM = 2'd0,
      WIN_130 = 2'd1,
      WIN_150 = 2'd2
   } win_e;

   typedef enum logic {
      MODE_CCM = 1'b0,
      MODE_DEM = 1'b1
   } mode_e;

   typedef struct packed {
      logic emu_ok;
      win_e step;
      logic af_ok;
   } dem_cfg_t;

   localparam int RUN_TO_DEM = 0;
   localparam int RUN_TO_CCM = 1;

endpackage

// File: rtl/dem_cfg_decode.sv
module dem_cfg_decode
   import dem_pkg::*;
(
   input  logic     gpu_mode2,
   input  logic     cfg_emu,
   input  logic     cfg_aud,
   output dem_cfg_t cfg
);

   always_comb begin
      cfg = '{emu_ok: 1'b0, step: WIN_NOM, af_ok: 1'b0};
      if (!gpu_mode2) begin
         cfg.emu_ok = cfg_emu;
         cfg.step   = cfg_emu ? WIN_130 : WIN_NOM;
         cfg.af_ok  = 1'b0;
      end else begin
         cfg.emu_ok = 1'b1;
         cfg.step   = cfg_aud ? WIN_130 : WIN_150;
         cfg.af_ok  = cfg_aud & ~cfg_emu;
      end
   end

endmodule

// File: rtl/dem_pulse_class.sv
module dem_pulse_class #(
   parameter int BLANK_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_cmd,
   input  logic ph_pos,
   output logic pulse_vld,
   output logic pulse_neg
);

   localparam int BW = $clog2(BLANK_CYC + 1);

   initial begin : p_param_chk
      if (BLANK_CYC < 1) $fatal(1, "BLANK_CYC must be at least 1");
   end

   logic          hs_q;
   logic          low_vld;
   logic [BW-1:0] blank_cnt;
   logic          hold_q;
   logic          fall, rise, win_open;

   assign fall     = hs_q & ~hs_cmd;
   assign rise     = ~hs_q & hs_cmd;
   assign win_open = ~hs_cmd & low_vld & ~fall & (blank_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q      <= 1'b1;
         low_vld   <= 1'b0;
         blank_cnt <= '0;
      end else begin
         hs_q <= hs_cmd;
         if (fall) begin
            low_vld   <= 1'b1;
            blank_cnt <= BW'(BLANK_CYC - 1);
         end else begin
            if (rise) low_vld <= 1'b0;
            if (~hs_cmd && blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hold_q <= 1'b0;
      else if (rise | fall)       hold_q <= 1'b0;
      else if (win_open & ph_pos) hold_q <= 1'b1;
   end

   assign pulse_vld = rise & low_vld;
   assign pulse_neg = hold_q;

endmodule

// File: rtl/dem_run_cnt.sv
module dem_run_cnt #(
   parameter int RUN_LEN = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic                           inc,
   output logic                           hit,
   output logic [$clog2(RUN_LEN+1)-1:0]   count
);

   localparam int CW = $clog2(RUN_LEN + 1);

   initial begin : p_param_chk
      if (RUN_LEN < 2) $fatal(1, "RUN_LEN must be at least 2");
   end

   assign hit = inc & (count == CW'(RUN_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         count <= '0;
      else if (clr | hit) count <= '0;
      else if (inc)       count <= count + 1'b1;
   end

endmodule

// File: rtl/dem_af_timer.sv
module dem_af_timer #(
   parameter int AF_PERIOD = 8750,
   parameter int AF_WIDTH  = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic pulse
);

   localparam int TW = $clog2(AF_PERIOD + 1);

   initial begin : p_param_chk
      if (AF_WIDTH < 1 || AF_WIDTH >= AF_PERIOD)
         $fatal(1, "AF_WIDTH must be in 1..AF_PERIOD-1");
   end

   logic [TW-1:0] tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          tick <= '0;
      else if (!en)                        tick <= '0;
      else if (tick == TW'(AF_PERIOD - 1)) tick <= '0;
      else                                 tick <= tick + 1'b1;
   end

   assign pulse = en & (tick >= TW'(AF_PERIOD - AF_WIDTH));

endmodule

// File: rtl/dem_ctrl.sv
module dem_ctrl
   import dem_pkg::*;
#(
   parameter int BLANK_CYC  = 10,
   parameter int RUN_LEN    = 3,
   parameter int AF_PERIOD  = 8750,
   parameter int AF_WIDTH   = 50,
   parameter bit AF_PRESENT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hs_cmd,
   input  logic       ph_pos,
   input  logic       gpu_mode2,
   input  logic       cfg_emu,
   input  logic       cfg_aud,
   output logic       dem_active,
   output logic [1:0] win_sel,
   output logic       lg_pulse
);

   localparam int CW = $clog2(RUN_LEN + 1);

   dem_cfg_t         cfg;
   mode_e            mode_q;
   logic             pulse_vld, pulse_neg;
   logic [1:0]       run_inc, run_clr, run_hit;
   logic [1:0][CW-1:0] run_cnt;
   logic             af_en;

   dem_cfg_decode u_decode (
      .gpu_mode2 (gpu_mode2),
      .cfg_emu   (cfg_emu),
      .cfg_aud   (cfg_aud),
      .cfg       (cfg)
   );

   dem_pulse_class #(.BLANK_CYC(BLANK_CYC)) u_class (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_cmd    (hs_cmd),
      .ph_pos    (ph_pos),
      .pulse_vld (pulse_vld),
      .pulse_neg (pulse_neg)
   );

   always_comb begin
      run_inc[RUN_TO_DEM] = pulse_vld & pulse_neg & (mode_q == MODE_CCM) & cfg.emu_ok;
      run_clr[RUN_TO_DEM] = ~cfg.emu_ok | (mode_q == MODE_DEM) | (pulse_vld & ~pulse_neg);
      run_inc[RUN_TO_CCM] = pulse_vld & ~pulse_neg & (mode_q == MODE_DEM) & cfg.emu_ok;
      run_clr[RUN_TO_CCM] = ~cfg.emu_ok | (mode_q == MODE_CCM) | (pulse_vld & pulse_neg);
   end

   for (genvar d = 0; d < 2; d++) begin : g_run
      dem_run_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (run_clr[d]),
         .inc   (run_inc[d]),
         .hit   (run_hit[d]),
         .count (run_cnt[d])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mode_q <= MODE_CCM;
      else if (!cfg.emu_ok)         mode_q <= MODE_CCM;
      else if (run_hit[RUN_TO_DEM]) mode_q <= MODE_DEM;
      else if (run_hit[RUN_TO_CCM]) mode_q <= MODE_CCM;
   end

   assign dem_active = (mode_q == MODE_DEM);
   assign win_sel    = dem_active ? cfg.step : WIN_NOM;
   assign af_en      = dem_active & cfg.af_ok;

   if (AF_PRESENT) begin : g_af
      dem_af_timer #(.AF_PERIOD(AF_PERIOD), .AF_WIDTH(AF_WIDTH)) u_af (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (af_en),
         .pulse (lg_pulse)
      );
   end else begin : g_no_af
      logic unused_af;
      assign unused_af = af_en;
      assign lg_pulse  = 1'b0;
   end

endmodule

// File: rtl/dem_ctrl_chk.sv
module dem_ctrl_chk #(
   parameter int RUN_LEN = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          hs_cmd,
   input logic                          gpu_mode2,
   input logic                          cfg_emu,
   input logic                          cfg_aud,
   input logic                          dem_active,
   input logic [1:0]                    win_sel,
   input logic                          lg_pulse,
   input logic [$clog2(RUN_LEN+1)-1:0]  neg_run,
   input logic [$clog2(RUN_LEN+1)-1:0]  pos_run
);

   localparam int CW = $clog2(RUN_LEN + 1);

   // R9
   win_nom_ccm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dem_active |-> win_sel == 2'd0);

   // R9
   win_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_sel != 2'd3);

   // R7
   profile_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gpu_mode2 && !cfg_emu) |=> !dem_active);

   // R10
   af_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lg_pulse |-> dem_active);

   // R10
   af_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lg_pulse |-> (gpu_mode2 && cfg_aud && !cfg_emu));

   // R2
   entry_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dem_active) |-> ($past(hs_cmd) && !$past(hs_cmd, 2)));

   // R4
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (neg_run < CW'(RUN_LEN)) && (pos_run < CW'(RUN_LEN)));

endmodule

bind dem_ctrl dem_ctrl_chk #(.RUN_LEN(RUN_LEN)) u_dem_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hs_cmd     (hs_cmd),
   .gpu_mode2  (gpu_mode2),
   .cfg_emu    (cfg_emu),
   .cfg_aud    (cfg_aud),
   .dem_active (dem_active),
   .win_sel    (win_sel),
   .lg_pulse   (lg_pulse),
   .neg_run    (run_cnt[0]),
   .pos_run    (run_cnt[1])
);

// File: tb/test_dem_ctrl.sv
`timescale 1ns/1ps
module test_dem_ctrl;

   localparam int BLANK = 4;
   localparam int RUNL  = 3;
   localparam int AFP   = 120;
   localparam int AFW   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs_cmd = 1'b1, ph_pos = 1'b0;
   logic gpu_mode2 = 1'b0, cfg_emu = 1'b0, cfg_aud = 1'b0;
   logic dem_active, lg_pulse;
   logic [1:0] win_sel;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   int exp_mode = 0, exp_n = 0, exp_p = 0;

   always #2 clk = ~clk;

   dem_ctrl #(.BLANK_CYC(BLANK), .RUN_LEN(RUNL), .AF_PERIOD(AFP), .AF_WIDTH(AFW)) i_dem_ctrl (
      .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .ph_pos(ph_pos),
      .gpu_mode2(gpu_mode2), .cfg_emu(cfg_emu), .cfg_aud(cfg_aud),
      .dem_active(dem_active), .win_sel(win_sel), .lg_pulse(lg_pulse)
   );

   function automatic bit f_allow(bit m2, bit e);
      return m2 | e;
   endfunction

   function automatic int f_step(bit m2, bit e, bit a);
      if (!m2) return e ? 1 : 0;
      return a ? 1 : 2;
   endfunction

   function automatic bit f_af(bit m2, bit e, bit a);
      return m2 & a & ~e;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(bit m2, bit e, bit a);
      @(negedge clk);
      gpu_mode2 = m2; cfg_emu = e; cfg_aud = a;
      if (!f_allow(m2, e)) begin
         exp_mode = 0; exp_n = 0; exp_p = 0;
      end
   endtask

   // one switching cycle: lo clocks with hs low, ph_pos high only at index pa,
   // then hi (>=2) clocks with hs high; checks mode/window one clock after the rise
   task automatic pulse(int lo, int pa, int hi, bit noise, string req);
      bit neg;
      for (int k = 0; k < lo; k++) begin
         @(negedge clk);
         hs_cmd = 1'b0; ph_pos = (k == pa);
      end
      for (int j = 0; j < hi; j++) begin
         @(negedge clk);
         hs_cmd = 1'b1; ph_pos = noise;
         if (j == 0) begin
            neg = (pa >= BLANK) && (pa < lo);
            if (f_allow(gpu_mode2, cfg_emu)) begin
               if (exp_mode == 0) begin
                  if (neg) begin
                     exp_n++;
                     if (exp_n == RUNL) begin exp_mode = 1; exp_n = 0; end
                  end else exp_n = 0;
               end else begin
                  if (!neg) begin
                     exp_p++;
                     if (exp_p == RUNL) begin exp_mode = 0; exp_p = 0; end
                  end else exp_p = 0;
               end
            end
         end
         if (j == 1) begin
            chk(dem_active == exp_mode[0], req, dem_active, exp_mode);
            chk(int'(win_sel) == (exp_mode != 0 ? f_step(gpu_mode2, cfg_emu, cfg_aud) : 0),
                "R9 window", win_sel,
                exp_mode != 0 ? f_step(gpu_mode2, cfg_emu, cfg_aud) : 0);
            if (lg_pulse && !(exp_mode != 0 && f_af(gpu_mode2, cfg_emu, cfg_aud)))
               chk(1'b0, "R10 stray keep-alive", lg_pulse, 0);
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed;
      int first_rise, rise2, width, prev;
      bit seen;
      seed = $urandom(32'd20240611);

      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(dem_active == 1'b0, "R1 mode", dem_active, 0);
      chk(win_sel == 2'd0, "R1 window", win_sel, 0);
      chk(lg_pulse == 1'b0, "R1 keep-alive", lg_pulse, 0);
      rst_n = 1'b1;

      // R7 profile one, emulation forbidden
      set_cfg(0, 0, 0);
      for (int i = 0; i < 4; i++) pulse(8, 6, 3, 0, "R7 forbidden");

      // R4 / R2 / R7 interrupted then complete run
      set_cfg(0, 1, 0);
      pulse(8, 6, 3, 0, "R4 neg1");
      pulse(8, 6, 3, 0, "R4 neg2");
      pulse(8, -1, 3, 0, "R4 pos break");
      pulse(8, 6, 3, 0, "R4 neg1b");
      pulse(8, 6, 3, 0, "R4 neg2b");
      pulse(8, 6, 3, 0, "R2 third neg enters");
      chk(dem_active == 1'b1, "R2 entered", dem_active, 1);
      chk(win_sel == 2'd1, "R7 window 130", win_sel, 1);

      // R4 / R3 in emulation
      pulse(8, -1, 3, 0, "R4 pos1");
      pulse(8, -1, 3, 0, "R4 pos2");
      pulse(8, 7, 3, 0, "R4 neg break");
      pulse(8, -1, 3, 0, "R4 pos1b");
      pulse(8, -1, 3, 0, "R4 pos2b");
      pulse(8, -1, 3, 0, "R3 third pos exits");
      chk(dem_active == 1'b0, "R3 exited", dem_active, 0);

      // R5 blanking edge and high-phase noise
      for (int i = 0; i < 3; i++) pulse(8, BLANK - 1, 3, 0, "R5 blanked");
      for (int i = 0; i < 3; i++) pulse(8, -1, 3, 1, "R5 high noise");
      chk(dem_active == 1'b0, "R5 stays", dem_active, 0);
      // R6 single-clock comparator hit at window start and at last low clock
      pulse(8, BLANK, 3, 0, "R6 held a");
      pulse(8, 7, 3, 0, "R6 held b");
      pulse(BLANK + 1, BLANK, 3, 0, "R6 held c");
      chk(dem_active == 1'b1, "R6 entered", dem_active, 1);

      // R8 profile two windows
      set_cfg(1, 0, 0);
      @(negedge clk);
      chk(win_sel == 2'd2, "R8 window 150", win_sel, 2);
      set_cfg(1, 1, 1);
      @(negedge clk);
      chk(win_sel == 2'd1, "R8 window 130", win_sel, 1);
      chk(lg_pulse == 1'b0, "R10 inhibited", lg_pulse, 0);

      // R10 keep-alive: leave, arm straps, re-enter, time the pulses
      for (int i = 0; i < 3; i++) pulse(8, -1, 3, 0, "R3 exit for af");
      set_cfg(1, 0, 1);
      pulse(8, 6, 3, 0, "R10 pre1");
      pulse(8, 6, 3, 0, "R10 pre2");
      pulse(8, 6, 2, 0, "R10 entry");
      first_rise = -1; rise2 = -1; width = 0; prev = lg_pulse; seen = 1'b0;
      for (int n = 1; n < 3 * AFP; n++) begin
         @(negedge clk);
         if (lg_pulse && !prev) begin
            if (first_rise < 0) first_rise = n;
            else if (rise2 < 0) rise2 = n;
         end
         if (lg_pulse && first_rise >= 0 && rise2 < 0) width++;
         prev = lg_pulse;
      end
      chk(first_rise == AFP - AFW, "R10 first delay", first_rise, AFP - AFW);
      chk(width == AFW, "R10 width", width, AFW);
      chk(rise2 - first_rise == AFP, "R10 period", rise2 - first_rise, AFP);

      // R11 profile withdraws permission
      set_cfg(0, 0, 0);
      @(negedge clk);
      chk(dem_active == 1'b0, "R11 forced exit", dem_active, 1'b0);
      chk(win_sel == 2'd0, "R11 window", win_sel, 0);
      chk(lg_pulse == 1'b0, "R11 keep-alive off", lg_pulse, 0);
      set_cfg(0, 1, 0);
      pulse(8, 6, 3, 0, "R11 fresh1");
      pulse(8, 6, 3, 0, "R11 fresh2");

      // random traffic mixed across profiles (R2 R3 R4 R5 R6)
      for (int seg = 0; seg < 20; seg++) begin
         set_cfg(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)));
         for (int i = 0; i < 15; i++) begin
            int lo, pa, hi;
            lo = int'($urandom_range(1, 12));
            pa = int'($urandom_range(0, lo + 1)) - 1;
            hi = int'($urandom_range(2, 6));
            pulse(lo, pa, hi, bit'($urandom_range(0, 1)), "R4 random run");
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule